// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block puts a multi-output clock generator into its lowest-power state and brings it back. The power-down request comes in active low and unrelated to any clock. It is brought into a free-running control clock through flip-flops, and only then does it act. The controller closes three glitch-free output gates: CPU, PCI and REF. Each gate has its own source clock, and each output stops low.

Each gate reports back when it is closed. Once every output is confirmed low, the controller drops the oscillator enables. The slow REF domain has extra pipeline stages, so it parks several of its own cycles after the others.

On release, the oscillator enables come back first. A settling counter then runs, and after it the gates reopen, each on the low phase of its own source. A request that arrives during settling or reopening sends the block straight back through the stop sequence. A status output is high only while the oscillators are off.

Top module: `clk_stop_seq`

## Requirements
- R1: `pd_ni` is active low and is resynchronized in two `clk_i` flip-flops before it has any effect. A low level held for several `clk_i` cycles starts the stop sequence.
- R2: Every output stops low. A stopping output has its last falling edge within a few source cycles of the request. Every high pulse on an output lasts a full half period of its source, so there are no runt pulses on stop, on restart or on abort.
- R3: `vco_en_o` and `xtal_en_o` fall only after the acknowledgements of all three domains report their gate closed. The REF domain may take more than one of its cycles to park.
- R4: `off_o` is high exactly while the oscillators are off. Both enables are low in that state and high in every other state. The state holds while the request stays asserted.
- R5: After the request is released, the enables rise on the next state change. The gates then stay closed for `SETTLE_CYCLES` control cycles. After that, the outputs restart. The restart latency is at least the settling time and at most the settling time plus a small synchronizer and gate overhead. With the defaults, this is below 3 ms at a 100 MHz control clock.
- R6: No output has an edge while `vco_en_o` is low, and no output has an edge during settling.
- R7: A request during settling re-enters the stop sequence at once, without opening a gate. A request during reopening closes every gate again and reaches the off state without passing through normal running.
- R8: The sequence behaves the same whether the CPU source runs at 133 MHz or at 100 MHz.
- R9: After reset the block is settling: enables high, outputs low, `off_o` low. The outputs then come up within the R5 bound.
- R10: From normal running, the off state is entered as soon as all domains acknowledge. After an abort from reopening, the controller also waits `STOP_GUARD` control cycles, so that acknowledgements still in flight cannot be taken as final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_clk_i | input | 1 | CPU source clock from the VCO |
| pci_clk_i | input | 1 | PCI source clock from the VCO |
| ref_clk_i | input | 1 | REF source clock from the crystal |
| cpu_clk_o | output | 1 | Gated CPU clock |
| pci_clk_o | output | 1 | Gated PCI clock |
| ref_clk_o | output | 1 | Gated REF clock |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| off_o | output | 1 | High only while the oscillators are off |

## Verification
The bench builds the block with `SETTLE_CYCLES` = 20, `STOP_GUARD` = 48 and `REF_LAG` = 2. With these values a full restart takes a few hundred nanoseconds instead of milliseconds, which makes two things feasible. First, a request can be timed to land inside the settling window. Second, a request can land inside the reopening window, while the fast CPU gate is already open and the slow REF gate is still closed. The CPU source runs at 133 MHz for the first power cycle and at 100 MHz afterwards. The source clocks run only while their enable is high, so edges after shutdown and early edges during settling are both visible at the outputs.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int unsigned NUM_DOM = 3;
  localparam int unsigned DOM_CPU = 0;
  localparam int unsigned DOM_PCI = 1;
  localparam int unsigned DOM_REF = 2;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP,
    ST_OFF,
    ST_WARM,
    ST_RESTART
  } seq_state_e;
endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
  parameter int unsigned       WIDTH   = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_gate_dom.sv
// One output domain: request sync, optional lag, negedge enable register.
module clk_gate_dom #(
  parameter int unsigned LAG = 0
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic on_o
);
  logic run_s, run_l, en_q;

  sync_ff #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  generate
    if (LAG == 0) begin : g_nolag
      assign run_l = run_s;
    end else begin : g_lag
      logic [LAG-1:0] sh_q;
      always_ff @(posedge src_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= run_s;
          for (int i = 1; i < LAG; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign run_l = sh_q[LAG-1];
    end
  endgenerate

  // enable only changes while the source is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_l;
  end

  assign clk_o = src_clk_i & en_q;
  assign on_o  = en_q;
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import clk_stop_pkg::*;
#(
  parameter int unsigned N             = 3,
  parameter int unsigned SETTLE_CYCLES = 250000,
  parameter int unsigned STOP_GUARD    = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pd_i,
  input  logic [N-1:0] on_i,
  output logic         run_o,
  output logic         osc_en_o,
  output logic         off_o,
  output seq_state_e   state_o
);
  localparam int unsigned CNT_MAX = (SETTLE_CYCLES > STOP_GUARD) ? SETTLE_CYCLES : STOP_GUARD;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] GUARD_END   = CW'(STOP_GUARD);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (pd_i) begin
          state_d = ST_STOP;
          cnt_d   = GUARD_END;  // no request in flight: skip guard
        end
      end
      ST_STOP: begin
        if (on_i == '0 && cnt_q >= GUARD_END) state_d = ST_OFF;
        else if (cnt_q < GUARD_END)           cnt_d   = cnt_q + CW'(1);
      end
      ST_OFF: begin
        if (!pd_i) begin
          state_d = ST_WARM;
          cnt_d   = '0;
        end
      end
      ST_WARM: begin
        if (pd_i) begin
          state_d = ST_STOP;
          cnt_d   = GUARD_END;
        end else if (cnt_q == SETTLE_LAST) begin
          state_d = ST_RESTART;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_RESTART: begin
        if (pd_i) begin
          state_d = ST_STOP;
          cnt_d   = '0;         // run pulse may still be in flight
        end else if (&on_i) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WARM;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o    = (state_q == ST_RUN) || (state_q == ST_RESTART);
  assign osc_en_o = (state_q != ST_OFF);
  assign off_o    = (state_q == ST_OFF);
  assign state_o  = state_q;
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
  import clk_stop_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 250000,
  parameter int unsigned STOP_GUARD    = 64,
  parameter int unsigned CPU_LAG       = 0,
  parameter int unsigned PCI_LAG       = 0,
  parameter int unsigned REF_LAG       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic cpu_clk_i,
  input  logic pci_clk_i,
  input  logic ref_clk_i,
  output logic cpu_clk_o,
  output logic pci_clk_o,
  output logic ref_clk_o,
  output logic xtal_en_o,
  output logic vco_en_o,
  output logic off_o
);
  localparam int unsigned DOM_LAG [NUM_DOM] = '{CPU_LAG, PCI_LAG, REF_LAG};

  logic               pd_s, run, osc_en;
  logic [NUM_DOM-1:0] src_clk, out_clk, on_raw, on_s;
  seq_state_e         state;

  assign src_clk[DOM_CPU] = cpu_clk_i;
  assign src_clk[DOM_PCI] = pci_clk_i;
  assign src_clk[DOM_REF] = ref_clk_i;

  sync_ff #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_pd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~pd_ni),
    .q_o   (pd_s)
  );

  generate
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
      clk_gate_dom #(.LAG(DOM_LAG[g])) u_gate (
        .src_clk_i(src_clk[g]),
        .rst_ni   (rst_ni),
        .run_i    (run),
        .clk_o    (out_clk[g]),
        .on_o     (on_raw[g])
      );
    end
  endgenerate

  sync_ff #(.WIDTH(NUM_DOM), .STAGES(2), .RST_VAL('0)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (on_raw),
    .q_o   (on_s)
  );

  stop_fsm #(
    .N            (NUM_DOM),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .STOP_GUARD   (STOP_GUARD)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pd_i    (pd_s),
    .on_i    (on_s),
    .run_o   (run),
    .osc_en_o(osc_en),
    .off_o   (off_o),
    .state_o (state)
  );

  assign cpu_clk_o = out_clk[DOM_CPU];
  assign pci_clk_o = out_clk[DOM_PCI];
  assign ref_clk_o = out_clk[DOM_REF];
  assign xtal_en_o = osc_en;
  assign vco_en_o  = osc_en;
endmodule

// File: rtl/clk_stop_chk.sv
module clk_stop_chk
  import clk_stop_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         vco_en_i,
  input logic         off_i,
  input logic [N-1:0] outs_i,
  input logic         pd_s_i,
  input logic [N-1:0] on_s_i,
  input seq_state_e   state_i
);
  p_park_before_osc_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vco_en_i) |-> $past(on_s_i) == '0);

  p_quiet_when_osc_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vco_en_i |-> outs_i == '0);

  p_off_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i && pd_s_i |=> off_i);

  p_warm_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_WARM |-> outs_i == '0);

  p_abort_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_RESTART && pd_s_i |=> state_i == ST_STOP);
endmodule

bind clk_stop_seq clk_stop_chk #(.N(3)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vco_en_i(vco_en_o),
  .off_i   (off_o),
  .outs_i  ({ref_clk_o, pci_clk_o, cpu_clk_o}),
  .pd_s_i  (pd_s),
  .on_s_i  (on_s),
  .state_i (state)
);

// File: tb/test_clk_stop_seq.sv
`timescale 1ns/1ps
module test_clk_stop_seq;
  localparam int unsigned SETTLE = 20;
  localparam int unsigned GUARD  = 48;
  localparam real CLK_PER = 10.0;
  localparam real PCI_HALF = 15.0;
  localparam real REF_HALF = 35.0;
  localparam longint LAT_MIN = longint'(SETTLE * CLK_PER);
  localparam longint LAT_MAX = longint'((SETTLE + 5) * CLK_PER + 12.0 * REF_HALF);

  logic clk = 1'b0, rst_ni = 1'b0, pd_ni = 1'b1;
  logic cpu_src = 1'b0, pci_src = 1'b0, ref_src = 1'b0;
  logic cpu_clk_o, pci_clk_o, ref_clk_o, xtal_en_o, vco_en_o, off_o;
  real  cpu_half = 3.75;

  int n_chk = 0, n_fail = 0, runt = 0, bad_edge = 0;
  int n_cpu = 0, n_pci = 0, n_ref = 0;
  bit mon_en = 1'b0, done = 1'b0;

  typedef struct { bit off; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  clk_stop_seq #(.SETTLE_CYCLES(SETTLE), .STOP_GUARD(GUARD), .REF_LAG(2)) i_clk_stop_seq (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni),
    .cpu_clk_i(cpu_src), .pci_clk_i(pci_src), .ref_clk_i(ref_src),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .ref_clk_o(ref_clk_o),
    .xtal_en_o(xtal_en_o), .vco_en_o(vco_en_o), .off_o(off_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  // source models: run only while their oscillator is enabled
  initial forever begin
    if (vco_en_o === 1'b0) begin cpu_src = 1'b0; wait (vco_en_o === 1'b1); end
    #(cpu_half);
    if (vco_en_o !== 1'b0) cpu_src = ~cpu_src;
  end
  initial forever begin
    if (vco_en_o === 1'b0) begin pci_src = 1'b0; wait (vco_en_o === 1'b1); end
    #(PCI_HALF);
    if (vco_en_o !== 1'b0) pci_src = ~pci_src;
  end
  initial forever begin
    if (xtal_en_o === 1'b0) begin ref_src = 1'b0; wait (xtal_en_o === 1'b1); end
    #(REF_HALF);
    if (xtal_en_o !== 1'b0) ref_src = ~ref_src;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // edge and pulse-width monitors
  realtime cpu_r, pci_r, ref_r;
  always @(posedge cpu_clk_o) begin n_cpu++; cpu_r = $realtime; if (mon_en && vco_en_o !== 1'b1) bad_edge++; end
  always @(posedge pci_clk_o) begin n_pci++; pci_r = $realtime; if (mon_en && vco_en_o !== 1'b1) bad_edge++; end
  always @(posedge ref_clk_o) begin n_ref++; ref_r = $realtime; if (mon_en && xtal_en_o !== 1'b1) bad_edge++; end
  always @(negedge cpu_clk_o) if (mon_en && ($realtime - cpu_r) < cpu_half - 0.01) runt++;
  always @(negedge pci_clk_o) if (mon_en && ($realtime - pci_r) < PCI_HALF - 0.01) runt++;
  always @(negedge ref_clk_o) if (mon_en && ($realtime - ref_r) < REF_HALF - 0.01) runt++;

  // scoreboard monitor for off_o transitions
  always @(off_o) if (mon_en) begin
    #1;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4", "unexpected off_o change", longint'(off_o), 0);
    end else begin
      cur = exp_q.pop_front();
      chk(off_o == cur.off, "R4", {cur.tag, " off_o value"}, longint'(off_o), longint'(cur.off));
      if (cur.off) begin
        chk({ref_clk_o, pci_clk_o, cpu_clk_o} == 3'b000, "R3",
            {cur.tag, " outputs low at osc off"}, longint'({ref_clk_o, pci_clk_o, cpu_clk_o}), 0);
        chk(!vco_en_o && !xtal_en_o, "R4", {cur.tag, " enables low in off"},
            longint'({vco_en_o, xtal_en_o}), 0);
      end else begin
        chk(vco_en_o && xtal_en_o, "R4", {cur.tag, " enables high after off"},
            longint'({vco_en_o, xtal_en_o}), 3);
      end
    end
  end

  function automatic int edges();
    return n_cpu + n_pci + n_ref;
  endfunction

  task automatic power_down(input string tag);
    int e0, max_e, q0;
    exp_q.push_back('{1'b1, tag});
    e0 = n_cpu;
    max_e = int'(80.0 / (2.0 * cpu_half)) + 2;
    pd_ni = 1'b0;
    wait (off_o === 1'b1);
    #2;
    chk((n_cpu - e0) >= 1 && (n_cpu - e0) <= max_e, "R2",
        {tag, " cpu edges before park"}, n_cpu - e0, max_e);
    q0 = edges();
    #400;
    chk(edges() == q0, "R6", {tag, " no edges while off"}, edges() - q0, 0);
    chk(off_o === 1'b1, "R1", {tag, " held request keeps off"}, longint'(off_o), 1);
  endtask

  task automatic power_up(input string tag);
    realtime t0;
    longint lat;
    exp_q.push_back('{1'b0, tag});
    pd_ni = 1'b1;
    t0 = $realtime;
    @(posedge ref_clk_o);
    lat = longint'($realtime - t0);
    chk(lat >= LAT_MIN, "R5", {tag, " restart not before settling"}, lat, LAT_MIN);
    chk(lat <= LAT_MAX, "R5", {tag, " restart latency bound"}, lat, LAT_MAX);
    #300;
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int e0;
    realtime t0;
    longint lat;
    #23;
    rst_ni = 1'b1;
    t0 = $realtime;
    #1;
    mon_en = 1'b1;
    // R9 reset state
    chk(off_o === 1'b0, "R9", "off_o after reset", longint'(off_o), 0);
    chk(vco_en_o === 1'b1, "R9", "vco_en after reset", longint'(vco_en_o), 1);
    chk(xtal_en_o === 1'b1, "R9", "xtal_en after reset", longint'(xtal_en_o), 1);
    chk({ref_clk_o, pci_clk_o, cpu_clk_o} == 3'b000, "R9", "outputs low after reset",
        longint'({ref_clk_o, pci_clk_o, cpu_clk_o}), 0);
    @(posedge ref_clk_o);
    lat = longint'($realtime - t0);
    chk(lat >= LAT_MIN && lat <= LAT_MAX, "R9", "bring-up latency", lat, LAT_MAX);
    #300;

    // R8: CPU at 133 MHz
    power_down("R8 133MHz");
    cpu_half = 5.0;
    // R8: CPU at 100 MHz
    power_up("R8 100MHz");
    power_down("R8 100MHz");

    // R7: abort during settling
    exp_q.push_back('{1'b0, "R7 warm release"});
    pd_ni = 1'b1;
    e0 = edges();
    #80;
    exp_q.push_back('{1'b1, "R7 warm abort"});
    pd_ni = 1'b0;
    wait (off_o === 1'b0);
    wait (off_o === 1'b1);
    #2;
    chk(edges() == e0, "R7", "no output edge during aborted settling", edges() - e0, 0);

    // R7/R10: abort during reopening
    exp_q.push_back('{1'b0, "R7 restart release"});
    pd_ni = 1'b1;
    e0 = n_cpu;
    #((SETTLE + 8) * CLK_PER);
    exp_q.push_back('{1'b1, "R10 restart abort"});
    pd_ni = 1'b0;
    wait (off_o === 1'b0);
    wait (off_o === 1'b1);
    #2;
    chk(n_cpu > e0, "R7", "cpu gate had reopened before abort", n_cpu - e0, 1);
    #200;

    power_up("R10 final");
    #1;
    chk(exp_q.size() == 0, "R4", "all expected off transitions seen", exp_q.size(), 0);
    chk(runt == 0, "R2", "runt pulses", runt, 0);
    chk(bad_edge == 0, "R6", "edges with oscillator off", bad_edge, 0);
    finish_run();
  end
endmodule